// File: doc/BRIEF.md
# Key-Guarded Clock Configuration Register Bank

This block holds the configuration words of a clock manager: one control word and one analog word per PLL, and a control/divisor pair per output clock selector. Software reaches it over a simple single-cycle bus (valid, write, byte address, access size, write data, combinational read data). Every write must carry a fixed key in its top byte. A write without that key is thrown away. An accepted write has the key byte cleared before it is stored.

Word 0 is not storage. Reading it returns a live lock summary: each PLL's bit is computed from the power-down flag in its analog word and the analog-reset flag in its control word. Downstream divider and PLL models take the stored words from a flat configuration output. After every accepted write, one-cycle refresh strobes tell them which register, which PLL or which selector changed.

With the default parameters (4 PLLs, 4 selectors), the word map is as follows. Word 0 is the lock summary. Words 1–4 are the PLL control words (analog reset at bit 8). Words 5–8 are the PLL analog words (power-down at bit 16). Words 9–16 hold selector i as a control word at 9+2i with its divisor at 10+2i.

Top module: `clkreg_bank`

## Requirements
- R1: A write whose bits 31:24 differ from 0x5A changes no register and raises no strobe.
- R2: An accepted write stores the data with bits 31:24 forced to zero; the new value reads back from the cycle after the write edge.
- R3: A write with byte address bits 1:0 not zero, or with a size code other than 2 (word), is ignored, and such a read returns zero.
- R4: PLL i is locked (pll_locked[i]=1) exactly when bit 16 of its analog word and bit 8 of its control word are both zero.
- R5: A read of word 0 returns PLL i's lock state at bit 8+i and zeros elsewhere; writes to word 0 are ignored.
- R6: Reset sets each PLL control word to 0x00000100, PLL analog word i to 0x00010020+i, each selector control word to 0, and each selector divisor to 0x00001000, so every PLL reads unlocked.
- R7: A write to selector i's control word (9+2i) or divisor word (10+2i) pulses mux_upd[i] alone for one cycle.
- R8: Each accepted write pulses reg_upd bit equal to the word index for exactly the one cycle after the write edge.
- R9: A write to PLL i's control word (1+i) or analog word (5+i) pulses pll_upd[i] alone for one cycle.
- R10: Word indices at or above 17 are not implemented: writes are ignored and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_size | input | 2 | 0 byte, 1 half, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data including key byte |
| bus_rdata | output | 32 | Combinational read data |
| cfg_words | output | 544 | All words flat, word k at bits 32k+31:32k (word 0 is zero) |
| reg_upd | output | 17 | Per-word refresh strobe |
| pll_upd | output | 4 | Per-PLL refresh strobe |
| mux_upd | output | 4 | Per-selector refresh strobe |
| pll_locked | output | 4 | Live lock state per PLL |

## Verification
A write that clears the last blocking flag of a PLL changes its lock state in the same cycle as the pll_upd pulse and the reg_upd pulse for that word. A read of word 0 issued in the very next cycle must already show the new lock bit. The bench provokes this with directed sequences that release a PLL one flag at a time, and with random keyed writes to control and analog words. It compares the strobes and an immediate lock read against a bench model of the register contents.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned KEY_LSB = 24;
  localparam logic [7:0]  ACCESS_KEY = 8'h5A;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  function automatic logic key_matches(input logic [WORD_W-1:0] d);
    return d[WORD_W-1:KEY_LSB] == ACCESS_KEY;
  endfunction

  function automatic logic [WORD_W-1:0] strip_key(input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    r = d;
    r[WORD_W-1:KEY_LSB] = '0;
    return r;
  endfunction

  // Power-on contents of word idx; word map: 0 lock, then control words,
  // then analog words, then selector control/divisor pairs.
  function automatic logic [WORD_W-1:0] reset_word(input int idx, input int npll,
                                                   input int nmux, input int anarst_bit,
                                                   input int pwrdn_bit);
    logic [WORD_W-1:0] r;
    r = '0;
    if (idx >= 1 && idx < 1 + npll)
      r[anarst_bit] = 1'b1;
    else if (idx >= 1 + npll && idx < 1 + 2*npll) begin
      r = WORD_W'(32'h20 + (idx - 1 - npll));
      r[pwrdn_bit] = 1'b1;
    end else if (idx >= 1 + 2*npll && idx < 1 + 2*npll + 2*nmux) begin
      if (((idx - 1 - 2*npll) % 2) == 1) r = WORD_W'(32'h1000);
    end
    return r;
  endfunction
endpackage

// File: rtl/clkreg_decode.sv
module clkreg_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 17,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                        bus_valid,
  input  logic                        bus_write,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [1:0]                  bus_size,
  input  logic [clkreg_pkg::WORD_W-1:0] bus_wdata,
  output logic                        wr_en,
  output logic [IDX_W-1:0]            acc_idx,
  output logic [clkreg_pkg::WORD_W-1:0] wr_val,
  output logic                        rd_ok,
  output logic                        acc_legal
);
  import clkreg_pkg::*;

  logic [ADDR_W-3:0] word_addr;
  logic              aligned, in_range;

  assign word_addr = bus_addr[ADDR_W-1:2];
  assign aligned   = (bus_addr[1:0] == 2'b00) && (acc_size_e'(bus_size) == SZ_WORD);
  assign in_range  = 32'(word_addr) < NUM_REGS;
  assign acc_legal = aligned && in_range;
  assign acc_idx   = IDX_W'(word_addr);

  // word 0 is the computed lock summary and never storage
  assign wr_en  = bus_valid && bus_write && acc_legal && (acc_idx != '0)
                  && key_matches(bus_wdata);
  assign wr_val = strip_key(bus_wdata);
  assign rd_ok  = bus_valid && !bus_write && acc_legal;
endmodule

// File: rtl/clkreg_store.sv
module clkreg_store #(
  parameter int unsigned NUM_PLL    = 4,
  parameter int unsigned NUM_MUX    = 4,
  parameter int unsigned ANARST_BIT = 8,
  parameter int unsigned PWRDN_BIT  = 16,
  localparam int unsigned NUM_REGS  = 1 + 2*NUM_PLL + 2*NUM_MUX,
  localparam int unsigned IDX_W     = $clog2(NUM_REGS),
  localparam int unsigned CM_BASE   = 1,
  localparam int unsigned ANA_BASE  = 1 + NUM_PLL,
  localparam int unsigned MUX_BASE  = 1 + 2*NUM_PLL
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [IDX_W-1:0]                    wr_idx,
  input  logic [clkreg_pkg::WORD_W-1:0]       wr_val,
  output logic [NUM_REGS*clkreg_pkg::WORD_W-1:0] words_flat,
  output logic [NUM_REGS-1:0]                 reg_upd,
  output logic [NUM_PLL-1:0]                  pll_upd,
  output logic [NUM_MUX-1:0]                  mux_upd
);
  import clkreg_pkg::*;

  logic [WORD_W-1:0]   regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++)
        regs_q[k] <= reset_word(k, NUM_PLL, NUM_MUX, ANARST_BIT, PWRDN_BIT);
      upd_q <= '0;
    end else begin
      for (int k = 1; k < NUM_REGS; k++)
        if (wr_en && 32'(wr_idx) == k) regs_q[k] <= wr_val;
      upd_q <= wr_en ? (NUM_REGS'(1) << wr_idx) : '0;
    end
  end

  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_flat
      if (k == 0) begin : g_lock_slot
        assign words_flat[WORD_W-1:0] = '0;
      end else begin : g_word
        assign words_flat[k*WORD_W +: WORD_W] = regs_q[k];
      end
    end
    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll_upd
      assign pll_upd[p] = upd_q[CM_BASE+p] | upd_q[ANA_BASE+p];
    end
    for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux_upd
      assign mux_upd[m] = upd_q[MUX_BASE+2*m] | upd_q[MUX_BASE+2*m+1];
    end
  endgenerate

  assign reg_upd = upd_q;

  AST_STORED_KEY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_val[WORD_W-1:KEY_LSB] == '0)); // R2
endmodule

// File: rtl/clkreg_lock.sv
module clkreg_lock #(
  parameter int unsigned NUM_PLL    = 4,
  parameter int unsigned NUM_REGS   = 17,
  parameter int unsigned ANARST_BIT = 8,
  parameter int unsigned PWRDN_BIT  = 16,
  parameter int unsigned LOCK_LSB   = 8,
  localparam int unsigned CM_BASE   = 1,
  localparam int unsigned ANA_BASE  = 1 + NUM_PLL
) (
  input  logic [NUM_REGS*clkreg_pkg::WORD_W-1:0] words_flat,
  output logic [NUM_PLL-1:0]                  locked,
  output logic [clkreg_pkg::WORD_W-1:0]       lock_word
);
  import clkreg_pkg::*;

  function automatic logic pll_ok(input logic [WORD_W-1:0] ctl_w,
                                  input logic [WORD_W-1:0] ana_w);
    return !ana_w[PWRDN_BIT] && !ctl_w[ANARST_BIT];
  endfunction

  generate
    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
      assign locked[p] = pll_ok(words_flat[(CM_BASE+p)*WORD_W +: WORD_W],
                                words_flat[(ANA_BASE+p)*WORD_W +: WORD_W]);
    end
  endgenerate

  always_comb begin
    lock_word = '0;
    lock_word[LOCK_LSB +: NUM_PLL] = locked;
  end
endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank #(
  parameter int unsigned NUM_PLL    = 4,
  parameter int unsigned NUM_MUX    = 4,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned ANARST_BIT = 8,
  parameter int unsigned PWRDN_BIT  = 16,
  parameter int unsigned LOCK_LSB   = 8,
  localparam int unsigned NUM_REGS  = 1 + 2*NUM_PLL + 2*NUM_MUX,
  localparam int unsigned IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [1:0]                    bus_size,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic [NUM_REGS*32-1:0]        cfg_words,
  output logic [NUM_REGS-1:0]           reg_upd,
  output logic [NUM_PLL-1:0]            pll_upd,
  output logic [NUM_MUX-1:0]            mux_upd,
  output logic [NUM_PLL-1:0]            pll_locked
);
  import clkreg_pkg::*;

  logic              wr_en, rd_ok, acc_legal;
  logic [IDX_W-1:0]  acc_idx;
  logic [WORD_W-1:0] wr_val, lock_word;

  clkreg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .wr_en(wr_en),
    .acc_idx(acc_idx), .wr_val(wr_val), .rd_ok(rd_ok), .acc_legal(acc_legal));

  clkreg_store #(.NUM_PLL(NUM_PLL), .NUM_MUX(NUM_MUX),
                 .ANARST_BIT(ANARST_BIT), .PWRDN_BIT(PWRDN_BIT)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(acc_idx), .wr_val(wr_val),
    .words_flat(cfg_words), .reg_upd(reg_upd), .pll_upd(pll_upd), .mux_upd(mux_upd));

  clkreg_lock #(.NUM_PLL(NUM_PLL), .NUM_REGS(NUM_REGS), .ANARST_BIT(ANARST_BIT),
                .PWRDN_BIT(PWRDN_BIT), .LOCK_LSB(LOCK_LSB)) u_lock (
    .words_flat(cfg_words), .locked(pll_locked), .lock_word(lock_word));

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) bus_rdata = (acc_idx == '0) ? lock_word : cfg_words[acc_idx*WORD_W +: WORD_W];
  end

  // named events for the checks below
  logic bad_key_wr, illegal_wr;
  assign bad_key_wr = bus_valid && bus_write && !key_matches(bus_wdata);
  assign illegal_wr = bus_valid && bus_write && !acc_legal;

  AST_BAD_KEY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key_wr |=> (reg_upd == '0)); // R1
  AST_ILLEGAL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |=> (reg_upd == '0)); // R3
  AST_REG_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_upd)); // R8
  AST_MUX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mux_upd)); // R7
  AST_PLL_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pll_upd)); // R9

  generate
    for (genvar p = 0; p < NUM_PLL; p++) begin : g_lock_chk
      AST_LOCK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_locked[p]) |-> pll_upd[p]); // R4
    end
  endgenerate
endmodule

// File: tb/clkreg_bank_test.sv
module clkreg_bank_test;
  localparam int NREG = 17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [1:0]        bus_size = 2'd2;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NREG*32-1:0] cfg_words;
  logic [NREG-1:0]   reg_upd;
  logic [3:0]        pll_upd, mux_upd, pll_locked;

  int n_chk = 0, n_fail = 0;
  logic [31:0] model [NREG];

  always #5 clk = ~clk;

  clkreg_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cfg_words(cfg_words), .reg_upd(reg_upd),
    .pll_upd(pll_upd), .mux_upd(mux_upd), .pll_locked(pll_locked));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_val(input int k);
    if (k >= 1 && k <= 4) return 32'h0000_0100;
    if (k >= 5 && k <= 8) return 32'h0001_0020 + 32'(k - 5);
    if (k >= 9 && k <= 16) return ((k - 9) % 2 == 1) ? 32'h0000_1000 : 32'h0;
    return 32'h0;
  endfunction

  function automatic logic [3:0] exp_locks();
    logic [3:0] r;
    for (int p = 0; p < 4; p++) r[p] = (model[5+p][16] == 1'b0) && (model[1+p][8] == 1'b0);
    return r;
  endfunction

  function automatic bit legal(input logic [7:0] a, input logic [1:0] sz);
    return (a[1:0] == 2'b00) && (sz == 2'd2) && (int'(a[7:2]) < NREG);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [1:0] sz);
    if (!legal(a, sz)) return 32'h0;
    if (a[7:2] == 0) return {20'h0, exp_locks(), 8'h0};
    return model[a[7:2]];
  endfunction

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
    bit acc;
    int k;
    logic [NREG-1:0] er;
    logic [3:0] ep, em;
    k = int'(a[7:2]);
    acc = legal(a, sz) && (k != 0) && (d[31:24] == 8'h5A);
    er = '0; ep = '0; em = '0;
    if (acc) begin
      model[k] = {8'h00, d[23:0]};
      er[k] = 1'b1;
      if (k >= 1 && k <= 4) ep[k-1] = 1'b1;
      if (k >= 5 && k <= 8) ep[k-5] = 1'b1;
      if (k >= 9 && k <= 16) em[(k-9)/2] = 1'b1;
    end
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
    chk(reg_upd == er, acc ? "R8 reg strobe" : "R1/R3/R5/R10 no strobe", 32'(reg_upd), 32'(er));
    chk(pll_upd == ep, "R9 pll strobe", 32'(pll_upd), 32'(ep));
    chk(mux_upd == em, "R7 mux strobe", 32'(mux_upd), 32'(em));
    chk(pll_locked == exp_locks(), "R4 lock state", 32'(pll_locked), 32'(exp_locks()));
    @(posedge clk); #1;
    chk(reg_upd == '0, "R8 strobe one cycle", 32'(reg_upd), 32'h0);
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [1:0] sz, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
    #1;
    e = exp_read(a, sz);
    chk(bus_rdata == e, req, bus_rdata, e);
    bus_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < NREG; k++) model[k] = init_val(k);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R6 reset contents and lock state
    for (int k = 0; k < NREG; k++) do_rd(8'(k*4), 2'd2, "R6 reset value");
    chk(pll_locked == 4'h0, "R6 all unlocked", 32'(pll_locked), 32'h0);
    chk(reg_upd == '0, "R6 no strobe", 32'(reg_upd), 32'h0);
    // R1 wrong key
    do_wr(8'h04, 32'hA500_0000, 2'd2);
    do_rd(8'h04, 2'd2, "R1 value kept");
    // R2 key stripped, R7 selector divisor
    do_wr(8'h28, 32'h5AFF_FFFF, 2'd2);
    do_rd(8'h28, 2'd2, "R2 stored without key");
    // R3 unaligned and narrow
    do_wr(8'h25, 32'h5A00_0077, 2'd2);
    do_wr(8'h24, 32'h5A00_0077, 2'd0);
    do_rd(8'h26, 2'd2, "R3 unaligned read zero");
    do_rd(8'h24, 2'd1, "R3 narrow read zero");
    // R5 write to lock word ignored
    do_wr(8'h00, 32'h5A00_0F00, 2'd2);
    do_rd(8'h00, 2'd2, "R5 lock word unchanged");
    // R10 out of range
    do_wr(8'h50, 32'h5A12_3456, 2'd2);
    do_rd(8'h50, 2'd2, "R10 out of range reads zero");
    // R4/R5/R9 release PLL2 one flag at a time
    do_wr(8'h0C, 32'h5A00_0000, 2'd2);
    do_rd(8'h00, 2'd2, "R4 one flag still blocks");
    do_wr(8'h1C, 32'h5A00_0022, 2'd2);
    do_rd(8'h00, 2'd2, "R5 lock bit 10 set");
    chk(pll_locked == 4'b0100, "R4 pll2 locked", 32'(pll_locked), 32'h4);
    // R7 selector control word, last selector
    do_wr(8'h3C, 32'h5A00_0003, 2'd2);
    do_wr(8'h40, 32'h5A00_2800, 2'd2);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [1:0]  sz;
      a  = 8'($urandom_range(0, 19) * 4);
      if ($urandom_range(0, 7) == 0) a[1:0] = 2'($urandom_range(1, 3));
      d  = $urandom();
      if ($urandom_range(0, 3) != 0) d[31:24] = 8'h5A;
      if ($urandom_range(0, 1) == 0) begin d[16] = 1'b0; d[8] = 1'b0; end
      sz = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 3)) : 2'd2;
      do_wr(a, d, sz);
      do_rd(8'($urandom_range(0, 18) * 4), 2'd2, "R2/R5 random readback");
    end
    for (int k = 1; k < NREG; k++)
      chk(cfg_words[k*32 +: 32] == model[k], "R2 config output", cfg_words[k*32 +: 32], model[k]);
    finish_run();
  end
endmodule